// File: doc/BRIEF.md
# Serial Receiver with Six-Byte Store and Request-to-Send Pacing

This block receives asynchronous serial characters on a single input line. It oversamples the line with a 16x tick, and it takes eight data bits least-significant first, an optional even parity bit and one stop bit. Each good character goes into a six-slot store. The oldest unread character is always visible on the data output, and a one-cycle read strobe removes it. An active-low request-to-send output asks the far transmitter to pause once the store begins to fill. It releases that request only after the store has been drained completely. A stop or suspend pulse also withdraws the request. After such a pulse the receiver keeps accepting characters for five frame times and then reports a timeout.

The control machine has three states. CT_OFF moves to CT_ON on a start pulse. CT_ON moves to CT_DRAIN on a stop or suspend pulse. CT_DRAIN moves back to CT_ON on a start pulse and to CT_OFF when the timeout window expires. A stop pulse always wins over a start pulse given in the same cycle.

The frame machine has seven states. FR_IDLE moves to FR_START on a low line sample while the receiver is enabled. FR_START returns to FR_IDLE if the mid-bit sample is high, and otherwise moves to FR_DATA. FR_DATA moves to FR_PARITY after the eighth bit if parity is on, or to FR_STOP if it is off. FR_PARITY moves to FR_STOP. FR_STOP returns to FR_IDLE on a high stop sample, and otherwise moves to FR_BREAK. FR_BREAK returns to FR_IDLE when the line goes high. If the line stays low for a whole frame, FR_BREAK moves to FR_WAITHI, which returns to FR_IDLE once the line is high.

Top module: `uart_rx_fifo_rts`

## Requirements
- R1: After reset the error bits are zero, no event pulses, and `rts_n_o` is high while flow control is on (the receiver starts stopped).
- R2: A frame is a low start bit confirmed at its middle sample, then 8 data bits least-significant first, each sampled at its centre, then a stop bit. A high stop sample stores the byte, and the oldest stored byte appears on `rx_data_o`.
- R3: The store holds six bytes. A seventh arrival with nothing read replaces the newest stored byte, and the fill count never exceeds six.
- R4: `rd_i` removes the byte on `rx_data_o`. `ev_rxdrdy_o` pulses exactly once each time a byte becomes the visible one: when a byte arrives into an empty store, or when a read exposes the next byte.
- R5: With flow control on, `rts_n_o` goes high once only four slots are free (two or more stored). It goes low again only when the store is empty.
- R6: A start pulse enables reception. A stop or suspend pulse drives `rts_n_o` high in the next cycle. Bytes are still received for 5 frame times (800 ticks without parity, 880 with parity), after which `ev_rxto_o` pulses once and further frames are ignored.
- R7: A low stop sample sets error bit 2 (framing), and no byte is stored.
- R8: A line held low for longer than one frame (10 bit times without parity, 11 with) sets error bit 3 (break), after the framing bit.
- R9: A start bit confirmed while all six slots hold unread data sets error bit 0 (overrun).
- R10: With `cfg_parity_i` high, a ninth bit follows the data and must equal the XOR of the data bits (even parity). A mismatch sets error bit 1 and the byte is still stored. With `cfg_parity_i` low, no parity bit is expected and bit 1 is never set.
- R11: Error bits are sticky. Writing 1 on `err_clr_i` clears the matching bit, but a new error in the same cycle wins. `ev_error_o` pulses whenever any error bit is newly set.
- R12: A falling `cts_n_i` gives `ev_cts_o` and, with `short_cts_start_i` high, acts as a start pulse. A rising `cts_n_i` gives `ev_ncts_o` and, with `short_ncts_stop_i` high, acts as a stop pulse.
- R13: With flow control off, `rts_n_o` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd_i | input | 1 | Serial data line, idle high |
| cts_n_i | input | 1 | Clear-to-send from the far side, active low |
| cfg_flow_i | input | 1 | Flow control enable |
| cfg_parity_i | input | 1 | Even parity bit present and checked |
| short_cts_start_i | input | 1 | Let a CTS-active event start reception |
| short_ncts_stop_i | input | 1 | Let a CTS-inactive event stop reception |
| task_start_i | input | 1 | Start-receive pulse |
| task_stop_i | input | 1 | Stop-receive pulse |
| task_suspend_i | input | 1 | Suspend pulse, same effect as stop on this receiver |
| rd_i | input | 1 | Read strobe, removes the visible byte |
| err_clr_i | input | 4 | Write-one-to-clear mask for the error bits |
| rx_data_o | output | 8 | Oldest unread byte |
| rts_n_o | output | 1 | Request-to-send, active low |
| ev_rxdrdy_o | output | 1 | Pulse: a new byte is visible |
| ev_rxto_o | output | 1 | Pulse: post-stop window expired |
| ev_error_o | output | 1 | Pulse: an error bit was set |
| ev_cts_o | output | 1 | Pulse: CTS became active |
| ev_ncts_o | output | 1 | Pulse: CTS became inactive |
| err_src_o | output | 4 | Sticky errors: bit0 overrun, bit1 parity, bit2 framing, bit3 break |

## Verification
The assertions assume that task pulses, read strobes and clear masks each last one cycle. They also assume that `tick16_i` never fires on two adjacent cycles and that flow and parity settings stay fixed while a frame or a drain window is in progress. The stimulus changes every input on the falling clock edge. It holds each serial bit for exactly 16 ticks and changes the configuration only while the line is idle and the store is empty. It never raises stop and start together.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        CT_OFF,
        CT_ON,
        CT_DRAIN
    } ctl_state_t;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PARITY,
        FR_STOP,
        FR_BREAK,
        FR_WAITHI
    } frm_state_t;

    localparam int ERR_W   = 4;
    localparam int ERR_OVR = 0;
    localparam int ERR_PAR = 1;
    localparam int ERR_FRM = 2;
    localparam int ERR_BRK = 3;

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rxd_i,
    input  logic              enable_i,
    input  logic              parity_en_i,
    input  logic              full_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              push_o,
    output logic [ERR_W-1:0]  err_set_o
);
    localparam int SUB_W   = $clog2(OVS);
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int RUN_MAX = (DATA_W + 3) * OVS;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);
    localparam logic [SUB_W-1:0] SUB_MID = SUB_W'(OVS / 2 - 1);
    localparam logic [SUB_W-1:0] SUB_END = SUB_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(DATA_W - 1);

    frm_state_t        state_q, state_d;
    logic [SUB_W-1:0]  sub_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic [RUN_W-1:0]  run_q;
    logic [RUN_W-1:0]  frame_len;
    logic              mid_hit, end_hit;

    assign frame_len = parity_en_i ? RUN_W'((DATA_W + 3) * OVS) : RUN_W'((DATA_W + 2) * OVS);
    assign mid_hit   = tick_i && (sub_q == SUB_MID);
    assign end_hit   = tick_i && (sub_q == SUB_END);
    assign byte_o    = shreg_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE:   if (tick_i && enable_i && !rxd_i) state_d = FR_START;
            FR_START:  if (mid_hit) state_d = rxd_i ? FR_IDLE : FR_DATA;
            FR_DATA:   if (end_hit && idx_q == IDX_END)
                           state_d = parity_en_i ? FR_PARITY : FR_STOP;
            FR_PARITY: if (end_hit) state_d = FR_STOP;
            FR_STOP:   if (end_hit) state_d = rxd_i ? FR_IDLE : FR_BREAK;
            FR_BREAK: begin
                if (rxd_i) state_d = FR_IDLE;
                else if (tick_i && run_q == frame_len) state_d = FR_WAITHI;
            end
            FR_WAITHI: if (rxd_i) state_d = FR_IDLE;
            default:   state_d = FR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        push_o             = (state_q == FR_STOP) && end_hit && rxd_i;
        err_set_o          = '0;
        err_set_o[ERR_FRM] = (state_q == FR_STOP) && end_hit && !rxd_i;
        err_set_o[ERR_PAR] = (state_q == FR_PARITY) && end_hit && (rxd_i != (^shreg_q));
        err_set_o[ERR_OVR] = (state_q == FR_START) && mid_hit && !rxd_i && full_i;
        err_set_o[ERR_BRK] = (state_q == FR_BREAK) && !rxd_i && tick_i && (run_q == frame_len);
    end

    // state register and bit datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            sub_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == FR_IDLE) begin
                sub_q <= '0;
                idx_q <= '0;
                run_q <= '0;
            end else begin
                if (tick_i) begin
                    if ((state_q == FR_START && sub_q == SUB_MID) || sub_q == SUB_END)
                        sub_q <= '0;
                    else
                        sub_q <= sub_q + 1'b1;
                    if (state_q != FR_WAITHI && run_q != RUN_W'(RUN_MAX))
                        run_q <= run_q + 1'b1;
                end
                if (state_q == FR_DATA && end_hit) begin
                    shreg_q <= {rxd_i, shreg_q[DATA_W-1:1]};
                    idx_q   <= idx_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
    import uart_rx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int OVS       = 16,
    parameter int TO_FRAMES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic parity_en_i,
    output logic rx_en_o,
    output logic halted_o,
    output logic rxto_o
);
    localparam int TO_MAX = TO_FRAMES * (DATA_W + 3) * OVS;
    localparam int CNT_W  = $clog2(TO_MAX + 1);

    ctl_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             rxto_q;

    assign limit = parity_en_i ? CNT_W'(TO_FRAMES * (DATA_W + 3) * OVS - 1)
                               : CNT_W'(TO_FRAMES * (DATA_W + 2) * OVS - 1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CT_OFF:   if (!stop_i && start_i) state_d = CT_ON;
            CT_ON:    if (stop_i) state_d = CT_DRAIN;
            CT_DRAIN: begin
                if (stop_i)                       state_d = CT_DRAIN;
                else if (start_i)                 state_d = CT_ON;
                else if (tick_i && cnt_q == limit) state_d = CT_OFF;
            end
            default:  state_d = CT_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CT_OFF;
            cnt_q   <= '0;
            rxto_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            rxto_q  <= (state_q == CT_DRAIN) && (state_d == CT_OFF);
            if (state_q != CT_DRAIN) cnt_q <= '0;
            else if (tick_i)         cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        rx_en_o  = (state_q != CT_OFF);
        halted_o = (state_q != CT_ON);
        rxto_o   = rxto_q;
    end
endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store #(
    parameter int DEPTH = 6,
    parameter int W     = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [W-1:0]     din_i,
    input  logic             pop_i,
    output logic [W-1:0]     head_o,
    output logic [CNT_W-1:0] fill_o,
    output logic             rdy_o
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q, wr_prev;
    logic [CNT_W-1:0] fill_q;
    logic             pop_eff, overwrite, rdy_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign wr_prev   = (wr_q == '0) ? PTR_W'(DEPTH - 1) : wr_q - 1'b1;
    assign pop_eff   = pop_i && (fill_q != '0);
    assign overwrite = push_i && (fill_q == CNT_W'(DEPTH)) && !pop_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rd_q   <= '0;
            wr_q   <= '0;
            fill_q <= '0;
            rdy_q  <= 1'b0;
        end else begin
            if (push_i) begin
                if (overwrite) mem_q[wr_prev] <= din_i;
                else begin
                    mem_q[wr_q] <= din_i;
                    wr_q        <= ptr_inc(wr_q);
                end
            end
            if (pop_eff) rd_q <= ptr_inc(rd_q);
            fill_q <= fill_q + CNT_W'(push_i && !overwrite) - CNT_W'(pop_eff);
            rdy_q  <= (push_i && (fill_q == '0 || (pop_eff && fill_q == CNT_W'(1))))
                   || (pop_eff && fill_q >= CNT_W'(2));
        end
    end

    assign head_o = mem_q[rd_q];
    assign fill_o = fill_q;
    assign rdy_o  = rdy_q;
endmodule

// File: rtl/uart_rx_fifo_rts.sv
module uart_rx_fifo_rts
    import uart_rx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 6,
    parameter int RTS_FREE  = 4,
    parameter int OVS       = 16,
    parameter int TO_FRAMES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16_i,
    input  logic              rxd_i,
    input  logic              cts_n_i,
    input  logic              cfg_flow_i,
    input  logic              cfg_parity_i,
    input  logic              short_cts_start_i,
    input  logic              short_ncts_stop_i,
    input  logic              task_start_i,
    input  logic              task_stop_i,
    input  logic              task_suspend_i,
    input  logic              rd_i,
    input  logic [ERR_W-1:0]  err_clr_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rts_n_o,
    output logic              ev_rxdrdy_o,
    output logic              ev_rxto_o,
    output logic              ev_error_o,
    output logic              ev_cts_o,
    output logic              ev_ncts_o,
    output logic [ERR_W-1:0]  err_src_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [1:0]        rxd_sync_q;
    logic [2:0]        cts_sync_q;
    logic              start_eff, stop_eff;
    logic              rx_en, halted, push, full;
    logic [DATA_W-1:0] rx_byte;
    logic [ERR_W-1:0]  err_set, err_q;
    logic [CNT_W-1:0]  fill;
    logic              rts_hold_q, err_ev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_sync_q <= '1;
            cts_sync_q <= '1;
            rts_hold_q <= 1'b0;
            err_q      <= '0;
            err_ev_q   <= 1'b0;
        end else begin
            rxd_sync_q <= {rxd_sync_q[0], rxd_i};
            cts_sync_q <= {cts_sync_q[1:0], cts_n_i};
            if (fill == '0)                          rts_hold_q <= 1'b0;
            else if (fill >= CNT_W'(DEPTH - RTS_FREE)) rts_hold_q <= 1'b1;
            err_q    <= (err_q & ~err_clr_i) | err_set;
            err_ev_q <= |err_set;
        end
    end

    assign ev_cts_o  = cts_sync_q[2] && !cts_sync_q[1];
    assign ev_ncts_o = !cts_sync_q[2] && cts_sync_q[1];
    assign start_eff = task_start_i || (short_cts_start_i && ev_cts_o);
    assign stop_eff  = task_stop_i || task_suspend_i || (short_ncts_stop_i && ev_ncts_o);
    assign full      = (fill == CNT_W'(DEPTH));

    uart_rx_ctrl #(.DATA_W(DATA_W), .OVS(OVS), .TO_FRAMES(TO_FRAMES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick16_i),
        .start_i(start_eff), .stop_i(stop_eff), .parity_en_i(cfg_parity_i),
        .rx_en_o(rx_en), .halted_o(halted), .rxto_o(ev_rxto_o)
    );

    uart_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick_i(tick16_i), .rxd_i(rxd_sync_q[1]),
        .enable_i(rx_en), .parity_en_i(cfg_parity_i), .full_i(full),
        .byte_o(rx_byte), .push_o(push), .err_set_o(err_set)
    );

    uart_rx_store #(.DEPTH(DEPTH), .W(DATA_W), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push_i(push), .din_i(rx_byte), .pop_i(rd_i),
        .head_o(rx_data_o), .fill_o(fill), .rdy_o(ev_rxdrdy_o)
    );

    assign rts_n_o    = cfg_flow_i ? (rts_hold_q || halted) : 1'b0;
    assign err_src_o  = err_q;
    assign ev_error_o = err_ev_q;
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
    parameter int DEPTH    = 6,
    parameter int RTS_FREE = 4,
    parameter int CNT_W    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_flow_i,
    input logic             task_stop_i,
    input logic             task_suspend_i,
    input logic             rts_n_o,
    input logic             ev_rxdrdy_o,
    input logic             ev_error_o,
    input logic [3:0]       err_src_o,
    input logic [3:0]       err_clr_i,
    input logic [CNT_W-1:0] fill_i
);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i <= CNT_W'(DEPTH));

    assert_head_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rxdrdy_o |-> (fill_i != '0));

    assert_rts_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flow_i && $past(fill_i) >= CNT_W'(DEPTH - RTS_FREE)) |-> rts_n_o);

    assert_rts_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (task_stop_i || task_suspend_i) |=> (rts_n_o || !cfg_flow_i));

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_src_o & $past(err_src_o & ~err_clr_i)) == $past(err_src_o & ~err_clr_i)));

    assert_err_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_error_o |-> (err_src_o != '0));
endmodule

bind uart_rx_fifo_rts uart_rx_chk #(.DEPTH(DEPTH), .RTS_FREE(RTS_FREE), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_flow_i(cfg_flow_i), .task_stop_i(task_stop_i),
    .task_suspend_i(task_suspend_i), .rts_n_o(rts_n_o), .ev_rxdrdy_o(ev_rxdrdy_o),
    .ev_error_o(ev_error_o), .err_src_o(err_src_o), .err_clr_i(err_clr_i), .fill_i(fill)
);

// File: tb/uart_rx_fifo_rts_tb.sv
module uart_rx_fifo_rts_tb;
    localparam int BIT_CLK = 64;   // 16 ticks, one tick every 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [1:0] tdiv = '0;
    logic       rxd = 1'b1, cts_n = 1'b1, flow = 1'b1, par = 1'b0;
    logic       sh_cts = 1'b0, sh_ncts = 1'b0;
    logic       t_start = 1'b0, t_stop = 1'b0, t_susp = 1'b0, rd = 1'b0;
    logic [3:0] clr = '0;
    logic [7:0] rx_data;
    logic       rts_n, ev_rdy, ev_to, ev_err, ev_c, ev_nc;
    logic [3:0] err_src;

    int n_chk = 0, n_err = 0;
    int n_rdy = 0, n_to = 0, n_everr = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= tdiv + 1'b1;
        tick16 <= (tdiv == 2'd2);
        if (rst_n) begin
            if (ev_rdy) n_rdy++;
            if (ev_to)  n_to++;
            if (ev_err) n_everr++;
        end
    end

    uart_rx_fifo_rts u_dut (
        .clk(clk), .rst_n(rst_n), .tick16_i(tick16), .rxd_i(rxd), .cts_n_i(cts_n),
        .cfg_flow_i(flow), .cfg_parity_i(par), .short_cts_start_i(sh_cts),
        .short_ncts_stop_i(sh_ncts), .task_start_i(t_start), .task_stop_i(t_stop),
        .task_suspend_i(t_susp), .rd_i(rd), .err_clr_i(clr), .rx_data_o(rx_data),
        .rts_n_o(rts_n), .ev_rxdrdy_o(ev_rdy), .ev_rxto_o(ev_to), .ev_error_o(ev_err),
        .ev_cts_o(ev_c), .ev_ncts_o(ev_nc), .err_src_o(err_src)
    );

    function automatic logic even_par(input logic [7:0] b);
        return ^b;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic with_par, input logic bad_par,
                        input logic stop_v);
        rxd = 1'b0; wait_clk(BIT_CLK);
        for (int i = 0; i < 8; i++) begin rxd = b[i]; wait_clk(BIT_CLK); end
        if (with_par) begin rxd = even_par(b) ^ bad_par; wait_clk(BIT_CLK); end
        rxd = stop_v; wait_clk(BIT_CLK);
        rxd = 1'b1; wait_clk(BIT_CLK);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] v);
        @(negedge clk); v = rx_data; rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        wait_clk(2);
    endtask

    task automatic clear_errs();
        @(negedge clk); clr = 4'hF;
        @(negedge clk); clr = 4'h0;
        wait_clk(1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v, b;
        logic       p;
        int         r0;
        void'($urandom(32'd1234));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // R1 reset state
        check("R1 rts_n", rts_n, 1);
        check("R1 err_src", err_src, 0);
        check("R1 events", n_rdy + n_to + n_everr, 0);

        // R6 start
        pulse(t_start);
        check("R6 rts_n after start", rts_n, 0);

        // R2/R4/R5 single byte
        send(8'hA5, 0, 0, 1);
        check("R4 rdy count", n_rdy, 1);
        check("R2 head data", rx_data, 8'hA5);
        check("R5 rts_n one stored", rts_n, 0);
        send(8'h3C, 0, 0, 1);
        check("R4 no event for queued", n_rdy, 1);
        check("R5 rts_n two stored", rts_n, 1);
        read_byte(v);
        check("R2 first read", v, 8'hA5);
        check("R4 event on expose", n_rdy, 2);
        check("R4 next head", rx_data, 8'h3C);
        check("R5 rts_n stays high", rts_n, 1);
        read_byte(v);
        check("R4 second read", v, 8'h3C);
        check("R5 rts_n empty", rts_n, 0);

        // R3/R9 fill and overwrite
        for (int i = 0; i < 6; i++) send(8'h10 + 8'(i), 0, 0, 1);
        check("R9 no overrun at six", err_src[0], 0);
        send(8'h16, 0, 0, 1);
        check("R9 overrun", err_src[0], 1);
        for (int i = 0; i < 6; i++) begin
            read_byte(v);
            check("R3 store order", v, (i < 5) ? 8'h10 + 8'(i) : 8'h16);
        end
        check("R5 rts_n after drain", rts_n, 0);
        r0 = n_everr;
        clear_errs();
        check("R11 clear", err_src, 0);
        check("R11 event count", r0, 1);

        // R10 parity
        par = 1'b1;
        send(8'h5A, 1, 0, 1);
        check("R10 good parity", err_src, 0);
        read_byte(v);
        check("R10 data good par", v, 8'h5A);
        send(8'h5B, 1, 1, 1);
        check("R10 bad parity flag", err_src, 4'b0010);
        check("R11 error event", n_everr, 2);
        read_byte(v);
        check("R10 bad parity stored", v, 8'h5B);
        clear_errs();
        par = 1'b0;
        send(8'h77, 0, 0, 1);
        read_byte(v);
        check("R10 parity off", err_src, 0);

        // R7 framing
        r0 = n_rdy;
        send(8'h33, 0, 0, 0);
        check("R7 framing flag", err_src, 4'b0100);
        check("R7 nothing stored", n_rdy, r0);
        clear_errs();

        // R8 break
        rxd = 1'b0; wait_clk(13 * BIT_CLK);
        rxd = 1'b1; wait_clk(2 * BIT_CLK);
        check("R8 break and framing", err_src, 4'b1100);
        check("R8 no byte", n_rdy, r0);
        clear_errs();

        // R2/R10 random bytes
        for (int k = 0; k < 10; k++) begin
            b = 8'($urandom);
            p = 1'($urandom);
            par = p;
            send(b, p, 0, 1);
            read_byte(v);
            check("R2 random byte", v, b);
            check("R10 random clean", err_src, 0);
        end
        par = 1'b0;

        // R6 stop, drain and timeout
        r0 = n_rdy;
        pulse(t_stop);
        check("R6 rts_n after stop", rts_n, 1);
        send(8'hC3, 0, 0, 1);
        read_byte(v);
        check("R6 byte during drain", v, 8'hC3);
        wait_clk(1700);
        check("R6 no early timeout", n_to, 0);
        wait_clk(1200);
        check("R6 timeout pulse", n_to, 1);
        r0 = n_rdy;
        send(8'h99, 0, 0, 1);
        check("R6 ignored after timeout", n_rdy, r0);

        // R6 suspend
        pulse(t_start);
        check("R6 restart", rts_n, 0);
        pulse(t_susp);
        check("R6 rts_n after suspend", rts_n, 1);
        wait_clk(3400);
        check("R6 suspend timeout", n_to, 2);

        // R12 shortcuts
        sh_cts = 1'b1; sh_ncts = 1'b1;
        @(negedge clk); cts_n = 1'b0;
        wait_clk(8);
        check("R12 cts start", rts_n, 0);
        @(negedge clk); cts_n = 1'b1;
        wait_clk(8);
        check("R12 ncts stop", rts_n, 1);
        wait_clk(3400);
        check("R12 timeout after ncts", n_to, 3);

        // R13 flow off
        flow = 1'b0;
        wait_clk(2);
        check("R13 rts_n flow off", rts_n, 0);

        finish_run();
    end
endmodule